// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully-associative store that sits beside a direct-mapped cache. Every line that the main cache throws out is written into it, together with the full line address (tag and index) and a dirty flag. When the main cache misses, the miss address is presented to this buffer first. Only if the buffer also misses does the block raise a request towards the next memory level. This gives the few sets that conflict most some extra associativity.

A buffer hit returns the stored line and its dirty flag and removes the entry. In the usual swap case, the main cache evicts a line in the same cycle, and that line takes the freed place. When the buffer is full, a new line pushes out the oldest entry. If that entry is dirty, it leaves on a write-back output.

Entries are kept compacted in arrival order, with the oldest at the bottom. Removal on a hit closes the gap. This keeps the replacement order exact at a small cost in multiplexing.

Top module: `victim_cache`

## Requirements
- R1: After reset the buffer is empty and `rsp_valid`, `rsp_hit`, `nl_req_valid` and `wb_valid` are all 0.
- R2: A line inserted with `ins_valid` is found by a later lookup of the same line address. The lookup reports `rsp_hit`=1 and returns the inserted data on `rsp_data`.
- R3: Every cycle with `lk_valid`=1 produces `rsp_valid`=1 exactly one clock later. Cycles without a lookup produce `rsp_valid`=0.
- R4: A lookup that misses raises `nl_req_valid` with `nl_req_addr` equal to the lookup address, one clock later. A lookup that hits raises no next-level request.
- R5: A hit removes the entry, so an immediate second lookup of the same address misses.
- R6: When a hit and an insert occur in the same cycle, the inserted line takes the freed place. No line is pushed out and no write-back occurs, even if the buffer was full.
- R7: The buffer holds ENTRIES lines (4 or 8). An insert into a full buffer with no hit that cycle pushes out the entry inserted longest ago. Lines swapped in count as the newest.
- R8: A pushed-out line that is dirty appears on `wb_valid`/`wb_addr`/`wb_data` one clock after the insert. A pushed-out clean line is dropped with `wb_valid`=0.
- R9: A lookup is resolved against the contents before the same cycle's insert. A lookup of the address being inserted in that same cycle misses.
- R10: A hit returns the entry's stored dirty flag on `rsp_dirty`, where 1 means modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Evicted line from the main cache is present |
| ins_addr | input | AW | Full line address of the evicted line |
| ins_data | input | DW | Evicted line contents |
| ins_dirty | input | 1 | Evicted line is modified |
| lk_valid | input | 1 | Main-cache miss lookup request |
| lk_addr | input | AW | Line address that missed in the main cache |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_data | output | DW | Returned line on a hit |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| nl_req_valid | output | 1 | Request to the next memory level |
| nl_req_addr | output | AW | Line address for the next level |
| wb_valid | output | 1 | Dirty pushed-out line to write back |
| wb_addr | output | AW | Address of the written-back line |
| wb_data | output | DW | Data of the written-back line |

## Verification
Every result is due exactly one clock after the cycle whose inputs cause it. The hit/miss response, the next-level request and the write-back of a pushed-out line each pass through one output register. The bench changes inputs on the falling edge and lets one rising edge pass. It then compares all outputs at the following falling edge against a reference queue that it updates in the same step. No check ever looks at a value before its register has loaded.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // width of a counter that can hold 0..n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

  // width of an index into n slots
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int ENTRIES = 4,
  parameter int AW      = 8,
  localparam int IW     = vc_pkg::idx_w(ENTRIES),
  localparam int CW     = vc_pkg::cnt_w(ENTRIES)
) (
  input  logic [AW-1:0] key,
  input  logic [AW-1:0] slot_addr [ENTRIES],
  input  logic [CW-1:0] fill,
  output logic          any_hit,
  output logic [IW-1:0] hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = (CW'(g) < fill) && (slot_addr[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IW'(i);
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int ENTRIES = 4,
  parameter int AW      = 8,
  parameter int DW      = 16,
  localparam int IW     = vc_pkg::idx_w(ENTRIES),
  localparam int CW     = vc_pkg::cnt_w(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_rm,
  input  logic [IW-1:0] rm_idx,
  input  logic          do_ins,
  input  logic [AW-1:0] new_addr,
  input  logic [DW-1:0] new_data,
  input  logic          new_dirty,
  output logic [AW-1:0] slot_addr [ENTRIES],
  output logic [DW-1:0] slot_data [ENTRIES],
  output logic          slot_dirty [ENTRIES],
  output logic [CW-1:0] fill,
  output logic          push_evt,
  output logic [AW-1:0] push_addr,
  output logic [DW-1:0] push_data,
  output logic          push_dirty
);
  logic [AW-1:0] a_n [ENTRIES];
  logic [DW-1:0] d_n [ENTRIES];
  logic          y_n [ENTRIES];
  logic [CW-1:0] fill_n;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      a_n[i] = slot_addr[i];
      d_n[i] = slot_data[i];
      y_n[i] = slot_dirty[i];
    end
    fill_n     = fill;
    push_evt   = 1'b0;
    push_addr  = slot_addr[0];
    push_data  = slot_data[0];
    push_dirty = slot_dirty[0];
    // close the gap left by a hit
    if (do_rm) begin
      for (int i = 0; i < ENTRIES - 1; i++)
        if (IW'(i) >= rm_idx) begin
          a_n[i] = slot_addr[i+1];
          d_n[i] = slot_data[i+1];
          y_n[i] = slot_dirty[i+1];
        end
      fill_n = fill - 1'b1;
    end
    // append newest at the top of the occupied range
    if (do_ins) begin
      if (fill_n == CW'(ENTRIES)) begin
        push_evt = 1'b1;
        for (int i = 0; i < ENTRIES - 1; i++) begin
          a_n[i] = a_n[i+1];
          d_n[i] = d_n[i+1];
          y_n[i] = y_n[i+1];
        end
        a_n[ENTRIES-1] = new_addr;
        d_n[ENTRIES-1] = new_data;
        y_n[ENTRIES-1] = new_dirty;
      end else begin
        for (int i = 0; i < ENTRIES; i++)
          if (CW'(i) == fill_n) begin
            a_n[i] = new_addr;
            d_n[i] = new_data;
            y_n[i] = new_dirty;
          end
        fill_n = fill_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        slot_addr[i]  <= '0;
        slot_data[i]  <= '0;
        slot_dirty[i] <= 1'b0;
      end
    end else begin
      fill <= fill_n;
      for (int i = 0; i < ENTRIES; i++) begin
        slot_addr[i]  <= a_n[i];
        slot_data[i]  <= d_n[i];
        slot_dirty[i] <= y_n[i];
      end
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ENTRIES = 4,
  parameter int AW      = 8,
  parameter int DW      = 16,
  localparam int IW     = vc_pkg::idx_w(ENTRIES),
  localparam int CW     = vc_pkg::cnt_w(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  input  logic          ins_dirty,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_dirty,
  output logic          nl_req_valid,
  output logic [AW-1:0] nl_req_addr,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);
  logic [AW-1:0] slot_addr [ENTRIES];
  logic [DW-1:0] slot_data [ENTRIES];
  logic          slot_dirty [ENTRIES];
  logic [CW-1:0] fill;
  logic          any_hit;
  logic [IW-1:0] hit_idx;
  logic          take_hit;
  logic          push_evt;
  logic [AW-1:0] push_addr;
  logic [DW-1:0] push_data;
  logic          push_dirty;

  vc_match #(.ENTRIES(ENTRIES), .AW(AW)) match_i (
    .key(lk_addr), .slot_addr(slot_addr), .fill(fill),
    .any_hit(any_hit), .hit_idx(hit_idx)
  );

  assign take_hit = lk_valid && any_hit;

  vc_store #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .do_rm(take_hit), .rm_idx(hit_idx),
    .do_ins(ins_valid), .new_addr(ins_addr), .new_data(ins_data), .new_dirty(ins_dirty),
    .slot_addr(slot_addr), .slot_data(slot_data), .slot_dirty(slot_dirty), .fill(fill),
    .push_evt(push_evt), .push_addr(push_addr), .push_data(push_data), .push_dirty(push_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_data     <= '0;
      rsp_dirty    <= 1'b0;
      nl_req_valid <= 1'b0;
      nl_req_addr  <= '0;
      wb_valid     <= 1'b0;
      wb_addr      <= '0;
      wb_data      <= '0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= take_hit;
      rsp_data     <= slot_data[hit_idx];
      rsp_dirty    <= take_hit && slot_dirty[hit_idx];
      nl_req_valid <= lk_valid && !any_hit;
      nl_req_addr  <= lk_addr;
      wb_valid     <= push_evt && push_dirty;
      wb_addr      <= push_addr;
      wb_data      <= push_data;
    end
  end
endmodule

// File: rtl/victim_cache_chk.sv
module victim_cache_chk #(
  parameter int ENTRIES = 4,
  parameter int CW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic          lk_valid,
  input logic          take_hit,
  input logic          push_evt,
  input logic [CW-1:0] fill,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          nl_req_valid,
  input logic          wb_valid
);
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(ENTRIES));

  a_r3_rsp_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r4_hit_or_request: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, nl_req_valid}) == 1);

  a_r5_hit_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hit && !ins_valid) |=> fill == CW'($past(fill) - 1'b1));

  a_r6_swap_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hit && ins_valid) |=> (!wb_valid && fill == $past(fill)));

  a_r8_wb_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(push_evt));

  a_r7_push_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> (fill == CW'(ENTRIES) && !take_hit));
endmodule

bind victim_cache victim_cache_chk #(.ENTRIES(ENTRIES), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .lk_valid(lk_valid),
  .take_hit(take_hit), .push_evt(push_evt), .fill(fill),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .nl_req_valid(nl_req_valid),
  .wb_valid(wb_valid)
);

// File: tb/victim_cache_tb_top.sv
`timescale 1ns/1ps
module victim_cache_tb_top;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic          ins_dirty = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          rsp_valid, rsp_hit, rsp_dirty, nl_req_valid, wb_valid;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] nl_req_addr, wb_addr;

  always #4 clk = ~clk;

  victim_cache #(.ENTRIES(N), .AW(AW), .DW(DW)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference queue, index 0 = oldest
  logic [AW-1:0] q_a [N];
  logic [DW-1:0] q_d [N];
  logic          q_y [N];
  int            q_n = 0;

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a, input int salt);
    return DW'(a * 97 + salt * 13 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare at next falling edge
  task automatic op(input bit iv, input logic [AW-1:0] ia, input int salt, input bit idy,
                    input bit lv, input logic [AW-1:0] la, input string tag);
    bit e_hit = 0, e_wb = 0, e_y = 0;
    logic [DW-1:0] e_d = '0, e_wd = '0;
    logic [AW-1:0] e_wa = '0;
    int hi = -1;
    ins_valid = iv; ins_addr = ia; ins_data = line_of(ia, salt); ins_dirty = idy;
    lk_valid = lv; lk_addr = la;
    if (lv) for (int i = 0; i < q_n; i++) if (hi < 0 && q_a[i] == la) hi = i;
    if (hi >= 0) begin
      e_hit = 1; e_d = q_d[hi]; e_y = q_y[hi];
      for (int i = hi; i < q_n - 1; i++) begin q_a[i] = q_a[i+1]; q_d[i] = q_d[i+1]; q_y[i] = q_y[i+1]; end
      q_n--;
    end
    if (iv) begin
      if (q_n == N) begin
        e_wb = q_y[0]; e_wa = q_a[0]; e_wd = q_d[0];
        for (int i = 0; i < N - 1; i++) begin q_a[i] = q_a[i+1]; q_d[i] = q_d[i+1]; q_y[i] = q_y[i+1]; end
        q_n--;
      end
      q_a[q_n] = ia; q_d[q_n] = line_of(ia, salt); q_y[q_n] = idy; q_n++;
    end
    @(negedge clk);
    chk(rsp_valid == lv, {"R3 ", tag}, "rsp_valid", rsp_valid, lv);
    chk(rsp_hit == e_hit, {"R2 ", tag}, "rsp_hit", rsp_hit, e_hit);
    if (e_hit) begin
      chk(rsp_data == e_d, {"R2 ", tag}, "rsp_data", rsp_data, e_d);
      chk(rsp_dirty == e_y, {"R10 ", tag}, "rsp_dirty", rsp_dirty, e_y);
    end
    chk(nl_req_valid == (lv && !e_hit), {"R4 ", tag}, "nl_req_valid", nl_req_valid, lv && !e_hit);
    if (lv && !e_hit) chk(nl_req_addr == la, {"R4 ", tag}, "nl_req_addr", nl_req_addr, la);
    chk(wb_valid == e_wb, {"R8 ", tag}, "wb_valid", wb_valid, e_wb);
    if (e_wb) begin
      chk(wb_addr == e_wa, {"R8 ", tag}, "wb_addr", wb_addr, e_wa);
      chk(wb_data == e_wd, {"R8 ", tag}, "wb_data", wb_data, e_wd);
    end
    ins_valid = 0; lk_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(!rsp_valid && !rsp_hit && !nl_req_valid && !wb_valid, "R1", "outputs after reset",
        {rsp_valid, rsp_hit, nl_req_valid, wb_valid}, 0);
    op(0, 0, 0, 0, 1, 8'd5, "R1 empty miss");
    for (int a = 1; a <= 4; a++) op(1, AW'(a), 1, a[0], 0, 0, "R2 fill");
    op(0, 0, 0, 0, 1, 8'd3, "R10 dirty hit");
    op(0, 0, 0, 0, 1, 8'd3, "R5 removed");
    op(1, 8'd9, 2, 0, 0, 0, "R7 refill");
    op(1, 8'd10, 2, 1, 0, 0, "R7 R8 push dirty oldest");
    op(1, 8'd11, 2, 0, 0, 0, "R8 push clean oldest");
    op(1, 8'd12, 3, 1, 1, 8'd4, "R6 swap when full");
    op(0, 0, 0, 0, 1, 8'd12, "R6 swapped line present");
    op(1, 8'd20, 4, 1, 1, 8'd20, "R9 same-cycle lookup");
    op(0, 0, 0, 0, 1, 8'd20, "R9 later lookup");
    // near-exhaustive sweep: every address/insert/lookup mix over a small address set
    for (int k = 0; k < 4000; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      op(seed[20], AW'(seed[27:24] % 10), k, seed[21], seed[22], AW'(seed[31:28] % 10), "R7 sweep");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule